// File: doc/BRIEF.md
# ADC Conversion Channel Sequencer

This block decides which input channel an ADC converts next, working from a programmed list of up to sixteen channel numbers. A single trigger pulse starts a burst of conversions. The length of the burst depends on a runtime mode select:

- one channel;
- a run of channels whose length is the programmed group size;
- one full pass over the list;
- endless passes over the list.

For each conversion the sequencer raises a one-cycle start request that carries the selected channel number. It then waits for a done pulse from the converter. It reports each finished conversion as a result strobe tagged with its channel number.

A position pointer into the list survives between triggers. A burst that stops partway through the list resumes from that position on the next trigger. The pointer returns to the first entry when the last entry has been converted. It also returns to the first entry when software changes the mode or the list length while the block is idle. An end-of-sequence pulse marks the conversion of the last list entry. A stop input ends the endless mode after the conversion in flight.

Top module: `adc_chan_seq`

## Requirements
- R1: Mode code 0 (single step) converts exactly one list entry per accepted trigger and then moves the pointer to the following entry, wrapping after the last entry.
- R2: Mode code 1 (full pass) converts every entry from the pointer to the last entry in list order on one trigger, and leaves the pointer at entry 0.
- R3: Mode code 2 (endless) keeps converting in list order after one trigger, wrapping from the last entry to entry 0. It ends only after `stop_i` is seen, finishing at most the one conversion in flight.
- R4: Mode code 3 (burst) converts `grp_m1_i`+1 consecutive entries per trigger. A burst that would pass the last entry ends with the last entry, and the next trigger starts from entry 0.
- R5: Single-step mode produces the same channel and end-of-sequence sequence as burst mode with a group size of 1.
- R6: A conversion start happens only in the cycle after an accepted trigger or in the cycle after a result inside a running burst. No start occurs without a trigger.
- R7: A trigger that arrives while `busy_o` is high is ignored.
- R8: `eos_o` is a one-cycle pulse that occurs only together with `res_valid_o`, and only for list entry `len_m1_i`, the last entry.
- R9: Changing `mode_i` or `len_m1_i` while idle returns the pointer to entry 0. The list length is `len_m1_i`+1, from 1 to 16.
- R10: At most one conversion is outstanding at a time. Each result carries the channel number that was sent with its start request. Entry k of `list_i` sits in bits [5k+4:5k].
- R11: After reset the block is idle: `busy_o`, `conv_start_o`, `res_valid_o` and `eos_o` are all low, and the pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger pulse |
| stop_i | input | 1 | Ends a running burst after the current conversion |
| mode_i | input | 2 | 0 single step, 1 full pass, 2 endless, 3 burst |
| len_m1_i | input | 4 | List length minus one |
| grp_m1_i | input | 4 | Group size minus one (burst mode) |
| list_i | input | 80 | Channel list, 5 bits per entry, entry 0 in the low bits |
| conv_done_i | input | 1 | Converter finished the requested conversion |
| conv_start_o | output | 1 | One-cycle conversion start request |
| conv_chan_o | output | 5 | Channel for the start request |
| res_valid_o | output | 1 | Result strobe |
| res_chan_o | output | 5 | Channel tag of the result |
| eos_o | output | 1 | End-of-sequence pulse |
| busy_o | output | 1 | A burst is running |

## Verification
The checker watches the cycle-level protocol on every clock:

- a start request always has a cause;
- only one conversion is outstanding at a time;
- each result carries the tag of its start request;
- end-of-sequence appears only with the last entry's result and lasts one cycle;
- the outputs stay quiet while idle.

The channel order itself is left to the bench, which sweeps every list length with the single-step, full-pass and burst modes at several group sizes. These sweeps cover how many conversions each trigger yields, pointer carry-over between triggers, and the equivalence of single-step mode with group size 1. Dedicated bench scenarios cover endless mode with stop, the pointer clear on a configuration change, and triggers that are ignored while busy.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_STEP  = 2'd0,
    MODE_PASS  = 2'd1,
    MODE_LOOP  = 2'd2,
    MODE_BURST = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  // Next list position, wrapping after the last entry.
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned last);
    return (idx == last) ? 0 : idx + 1;
  endfunction

  // Whether the conversion that just finished closes the burst.
  function automatic logic burst_done(seq_mode_e m, logic at_last,
                                      int unsigned cnt, int unsigned grp_m1);
    case (m)
      MODE_STEP:  return 1'b1;
      MODE_PASS:  return at_last;
      MODE_LOOP:  return 1'b0;
      default:    return at_last || (cnt == grp_m1);
    endcase
  endfunction

endpackage

// File: rtl/adc_seq_ptr.sv
module adc_seq_ptr
  import adc_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] last_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             at_last_o
);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (adv_i) idx_q <= IDX_W'(wrap_next(32'(idx_q), 32'(last_i)));
  end

  assign idx_o     = idx_q;
  assign at_last_o = (idx_q == last_i);

endmodule

// File: rtl/adc_seq_gcnt.sv
module adc_seq_gcnt #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [IDX_W-1:0] cnt_o
);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/adc_seq_mux.sv
module adc_seq_mux #(
  parameter int N     = 16,
  parameter int CH_W  = 5,
  parameter int IDX_W = 4
) (
  input  logic [N*CH_W-1:0] list_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [CH_W-1:0]   chan_o
);

  logic [CH_W-1:0] entry [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_entry
    assign entry[gi] = list_i[gi*CH_W +: CH_W];
  end

  assign chan_o = entry[idx_i];

endmodule

// File: rtl/adc_chan_seq.sv
module adc_chan_seq
  import adc_seq_pkg::*;
#(
  parameter  int LIST_MAX = 16,
  parameter  int CH_W     = 5,
  localparam int IDX_W    = $clog2(LIST_MAX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig_i,
  input  logic                     stop_i,
  input  logic [1:0]               mode_i,
  input  logic [IDX_W-1:0]         len_m1_i,
  input  logic [IDX_W-1:0]         grp_m1_i,
  input  logic [LIST_MAX*CH_W-1:0] list_i,
  input  logic                     conv_done_i,
  output logic                     conv_start_o,
  output logic [CH_W-1:0]          conv_chan_o,
  output logic                     res_valid_o,
  output logic [CH_W-1:0]          res_chan_o,
  output logic                     eos_o,
  output logic                     busy_o
);

  seq_state_e       state_q, state_d;
  seq_mode_e        mode_q;
  logic [IDX_W-1:0] len_q, grp_q;
  logic             stop_q;

  // Named internal events
  logic             idle_w, accept_w, cfg_chg_w, done_w, end_w, stop_w, at_last_w;
  logic [IDX_W-1:0] ptr_w, gcnt_w;

  assign idle_w    = (state_q == ST_IDLE);
  assign accept_w  = idle_w && trig_i;
  assign cfg_chg_w = idle_w && ((seq_mode_e'(mode_i) != mode_q) || (len_m1_i != len_q));
  assign done_w    = (state_q == ST_WAIT) && conv_done_i;
  assign stop_w    = stop_q || stop_i;
  assign end_w     = burst_done(mode_q, at_last_w, 32'(gcnt_w), 32'(grp_q)) || stop_w;

  // Configuration follows the inputs while idle and is frozen during a burst.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_STEP;
      len_q  <= '0;
      grp_q  <= '0;
    end else if (idle_w) begin
      mode_q <= seq_mode_e'(mode_i);
      len_q  <= len_m1_i;
      grp_q  <= grp_m1_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 stop_q <= 1'b0;
    else if (idle_w)            stop_q <= 1'b0;
    else if (stop_i)            stop_q <= 1'b1;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (trig_i) state_d = ST_START;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (done_w) state_d = end_w ? ST_IDLE : ST_START;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  adc_seq_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (cfg_chg_w),
    .adv_i     (done_w),
    .last_i    (len_q),
    .idx_o     (ptr_w),
    .at_last_o (at_last_w)
  );

  adc_seq_gcnt #(.IDX_W(IDX_W)) u_gcnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (accept_w),
    .inc_i (done_w),
    .cnt_o (gcnt_w)
  );

  adc_seq_mux #(.N(LIST_MAX), .CH_W(CH_W), .IDX_W(IDX_W)) u_mux (
    .list_i (list_i),
    .idx_i  (ptr_w),
    .chan_o (conv_chan_o)
  );

  assign conv_start_o = (state_q == ST_START);
  assign res_valid_o  = done_w;
  assign res_chan_o   = conv_chan_o;
  assign eos_o        = done_w && at_last_w;
  assign busy_o       = !idle_w;

endmodule

// File: rtl/adc_chan_seq_chk.sv
module adc_chan_seq_chk #(
  parameter int CH_W  = 5,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             conv_start_o,
  input logic [CH_W-1:0]  conv_chan_o,
  input logic             res_valid_o,
  input logic [CH_W-1:0]  res_chan_o,
  input logic             eos_o,
  input logic             busy_o,
  input logic [IDX_W-1:0] ptr_w,
  input logic [IDX_W-1:0] len_q
);

  logic [CH_W-1:0] tag_q;
  logic            pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (conv_start_o) begin
        tag_q  <= conv_chan_o;
        pend_q <= 1'b1;
      end else if (res_valid_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> ($past(trig_i) || $past(res_valid_o)));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> !pend_q);

  assert_result_tag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (pend_q && res_chan_o == tag_q));

  assert_eos_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |-> (res_valid_o && ptr_w == len_q));

  assert_eos_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |=> !eos_o);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!conv_start_o && !res_valid_o));

  assert_busy_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(trig_i));

endmodule

bind adc_chan_seq adc_chan_seq_chk #(.CH_W(CH_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_i       (trig_i),
  .conv_start_o (conv_start_o),
  .conv_chan_o  (conv_chan_o),
  .res_valid_o  (res_valid_o),
  .res_chan_o   (res_chan_o),
  .eos_o        (eos_o),
  .busy_o       (busy_o),
  .ptr_w        (ptr_w),
  .len_q        (len_q)
);

// File: tb/adc_chan_seq_bench.sv
`timescale 1ns/1ps
module adc_chan_seq_bench;

  localparam int LIST_MAX = 16;
  localparam int CH_W     = 5;
  localparam int LAT      = 3;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     trig_i = 1'b0;
  logic                     stop_i = 1'b0;
  logic [1:0]               mode_i = 2'd0;
  logic [3:0]               len_m1_i = 4'd0;
  logic [3:0]               grp_m1_i = 4'd0;
  logic [LIST_MAX*CH_W-1:0] list_i;
  logic                     conv_done_i = 1'b0;
  logic                     conv_start_o;
  logic [CH_W-1:0]          conv_chan_o;
  logic                     res_valid_o;
  logic [CH_W-1:0]          res_chan_o;
  logic                     eos_o;
  logic                     busy_o;

  always #5 clk = ~clk;

  adc_chan_seq u_adc_chan_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .stop_i(stop_i),
    .mode_i(mode_i), .len_m1_i(len_m1_i), .grp_m1_i(grp_m1_i),
    .list_i(list_i), .conv_done_i(conv_done_i),
    .conv_start_o(conv_start_o), .conv_chan_o(conv_chan_o),
    .res_valid_o(res_valid_o), .res_chan_o(res_chan_o),
    .eos_o(eos_o), .busy_o(busy_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int nlog = 0;
  int nstart = 0;
  int rcnt = 0;
  int cyc = 0;
  int log_ch [0:255];
  bit log_eos [0:255];

  // Bench model state
  int mp = 0, cur_m = -1, cur_len = -1, cur_g = 1;

  function automatic int chan(int i);
    return (i * 11 + 5) % 32;
  endfunction

  task automatic chk(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // Fixed-latency converter model plus result monitor
  always @(negedge clk) begin
    if (conv_start_o) rcnt = LAT;
    else if (rcnt > 0) rcnt = rcnt - 1;
    conv_done_i = (rcnt == 1) && !conv_start_o;
    #1;
    if (res_valid_o && nlog < 256) begin
      log_ch[nlog]  = int'(res_chan_o);
      log_eos[nlog] = eos_o;
      nlog++;
    end
    if (conv_start_o) nstart++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic set_cfg(int m, int len, int g);
    @(negedge clk);
    mode_i   = 2'(m);
    len_m1_i = 4'(len - 1);
    grp_m1_i = 4'(g - 1);
    if (m != cur_m || len != cur_len) mp = 0;
    cur_m = m; cur_len = len; cur_g = g;
    @(negedge clk);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic run_burst(string rq);
    int n;
    if (cur_m == 0)      n = 1;
    else if (cur_m == 1) n = cur_len - mp;
    else                 n = (cur_g < cur_len - mp) ? cur_g : cur_len - mp;
    nlog = 0; nstart = 0;
    pulse_trig();
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(nlog == n, rq, nlog, n);
    chk(nstart == n, "R6", nstart, n);
    for (int i = 0; i < n && i < nlog; i++) begin
      int idx = mp + i;
      chk(log_ch[i] == chan(idx), rq, log_ch[i], chan(idx));
      chk(log_eos[i] == (idx == cur_len - 1), "R8", int'(log_eos[i]), int'(idx == cur_len - 1));
    end
    mp = (mp + n) % cur_len;
  endtask

  initial begin
    int nstop;
    for (int i = 0; i < LIST_MAX; i++) list_i[i*CH_W +: CH_W] = CH_W'(chan(i));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(busy_o == 0, "R11", int'(busy_o), 0);
    chk(conv_start_o == 0, "R11", int'(conv_start_o), 0);
    chk(res_valid_o == 0 && eos_o == 0, "R11", int'(res_valid_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 0, "R11", int'(busy_o), 0);

    // Sweeps over every list length
    for (int len = 1; len <= LIST_MAX; len++) begin
      set_cfg(1, len, 1);
      for (int t = 0; t < 2; t++) run_burst("R2");
      set_cfg(0, len, 1);
      for (int t = 0; t <= len; t++) run_burst("R1");
      for (int g = 1; g <= 4; g++) begin
        set_cfg(3, len, g);
        for (int t = 0; t <= (len + g - 1) / g; t++) run_burst(g == 1 ? "R5" : "R4");
      end
    end

    // R7: trigger while busy is ignored
    set_cfg(1, 8, 1);
    nlog = 0;
    pulse_trig();
    repeat (4) @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(nlog == 8, "R7", nlog, 8);
    chk(busy_o == 0, "R7", int'(busy_o), 0);

    // R3: endless mode with stop
    set_cfg(2, 5, 1);
    nlog = 0;
    pulse_trig();
    while (nlog < 12) @(negedge clk);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
    nstop = nlog;
    chk(nstop >= 12 && nstop <= 13, "R3", nstop, 13);
    for (int i = 0; i < nstop; i++) begin
      chk(log_ch[i] == chan(i % 5), "R3", log_ch[i], chan(i % 5));
      chk(log_eos[i] == (i % 5 == 4), "R8", int'(log_eos[i]), int'(i % 5 == 4));
    end
    repeat (30) @(negedge clk);
    chk(nlog == nstop, "R3", nlog, nstop);

    // R9: configuration change while idle clears the pointer
    set_cfg(0, 6, 1);
    run_burst("R9");
    run_burst("R9");
    set_cfg(0, 7, 1);
    run_burst("R9");
    set_cfg(3, 7, 1);
    run_burst("R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule